// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block holds the 16-bit sleep control register of a power-management controller. Software reaches it through a byte or halfword port at byte offsets 0 and 1. A write that carries the sleep-enable bit is not stored. Instead, the sleep-type field is decoded into one-cycle request pulses for power off, suspend-to-RAM or suspend-to-disk. The power sequencer downstream consumes these pulses.

Bit 0 is the interrupt-routing enable (SCI enable). Software can write it, and two command inputs from platform firmware can also set or clear it. A static strap selects a fixed mode in which those commands have no effect and reset leaves the bit set. A second static input gives the sleep-type code that means suspend-to-disk. Both straps may change only while reset is held.

Top module: `pm_sleep_top`

## Requirements
- R1: After reset the register reads 0x0000 when `acpiOnly` is 0, and 0x0001 (bit 0 set) when `acpiOnly` is 1.
- R2: The sleep-enable bit (bit 13) is never stored. A read at offset 0 always shows bit 13 as 0.
- R3: A halfword write at offset 0 stores all bits except bit 13. A byte write at offset 0 stores the byte in bits 7:0 and clears bits 15:8. A halfword write at offset 1 is ignored.
- R4: A byte write at offset 1 replaces bits 15:8 and keeps bits 7:0. The byte's bit 5 acts as sleep-enable and its bits 4:2 act as the sleep type.
- R5: A read at byte offset n returns the register shifted right by 8·n bits, so offset 1 returns bits 15:8 in bits 7:0 with zeros above.
- R6: A write with sleep-enable set and sleep type (bits 12:10) equal to 0 raises `reqPowerOff` for exactly one cycle, in the cycle after the write.
- R7: A write with sleep-enable set and sleep type 1 raises `reqSuspend` for exactly one cycle, in the cycle after the write.
- R8: A write with sleep-enable set and a sleep type other than 0 or 1 that equals `diskCode` raises `reqDisk` in the cycle after the write. It then raises `reqPowerOff` in the cycle after that.
- R9: All other sleep types, and writes without sleep-enable, raise no request. Types 0 and 1 keep their fixed meaning even when `diskCode` equals them.
- R10: `sciSetCmd` sets bit 0. `sciClrCmd` clears bit 0 only when `sciSetCmd` is low. A command overrides a software write to bit 0 in the same cycle.
- R11: With `acpiOnly` set, both SCI commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acpiOnly | input | 1 | Static strap: fixed SCI-enable mode |
| diskCode | input | 3 | Static strap: sleep-type code meaning suspend-to-disk |
| busAddr | input | 1 | Byte offset within the register |
| busWr | input | 1 | Write strobe |
| busHalf | input | 1 | 1 = halfword access, 0 = byte access |
| busWdata | input | 16 | Write data, byte writes in bits 7:0 |
| busRdata | output | 16 | Read data for `busAddr` |
| sciSetCmd | input | 1 | Firmware command: set SCI enable |
| sciClrCmd | input | 1 | Firmware command: clear SCI enable |
| reqPowerOff | output | 1 | One-cycle soft power-off request |
| reqSuspend | output | 1 | One-cycle suspend-to-RAM request |
| reqDisk | output | 1 | One-cycle suspend-to-disk request |

## Verification
The bench builds the block with its default parameters: SCI enable at bit 0, sleep-enable at bit 13, and the sleep-type field at bits 12:10. These positions put a sleep request within reach of both a halfword write and a byte write at offset 1. The straps are changed across three resets. `diskCode` values of 4 and 7 exercise the two-pulse disk sequence. A `diskCode` of 1 shows that the fixed suspend code keeps its meaning and that unmatched codes stay silent. The fixed SCI mode is tested against both commands and against a software write to bit 0.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;
  localparam int RegW  = 16;
  localparam int LaneW = 8;
  localparam int Lanes = RegW / LaneW;
  localparam int AddrW = $clog2(Lanes);

  // Strobes from control to the register datapath
  typedef struct packed {
    logic loadFull;   // halfword write at offset 0
    logic loadLow;    // byte write at offset 0, upper byte cleared
    logic loadUpper;  // byte write at offset 1, lower byte kept
    logic sciSet;     // gated set command for the SCI bit
    logic sciClr;     // gated clear command for the SCI bit
  } ctrlStb_t;
endpackage

// File: rtl/pm_sleep_dp.sv
module pm_sleep_dp
  import pm_sleep_pkg::*;
#(
  parameter int SCI_BIT = 0,
  parameter int SLP_BIT = 13,
  parameter int TYP_LSB = 10,
  parameter int TYP_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acpiOnly,
  input  ctrlStb_t         stb,
  input  logic [RegW-1:0]  wrData,
  input  logic [AddrW-1:0] rdAddr,
  output logic [RegW-1:0]  rdData,
  output logic             wrSleep,
  output logic [TYP_W-1:0] wrType
);
  logic [RegW-1:0] regQ;
  logic [RegW-1:0] mergedVal;
  logic [RegW-1:0] regNext;
  logic            anyLoad;

  assign anyLoad = stb.loadFull | stb.loadLow | stb.loadUpper;

  // Value the write presents, after lane merging
  always_comb begin
    if (stb.loadUpper)
      mergedVal = {wrData[LaneW-1:0], regQ[LaneW-1:0]};
    else if (stb.loadLow)
      mergedVal = {{(RegW-LaneW){1'b0}}, wrData[LaneW-1:0]};
    else
      mergedVal = wrData;
  end

  assign wrSleep = mergedVal[SLP_BIT];
  assign wrType  = mergedVal[TYP_LSB +: TYP_W];

  always_comb begin
    regNext = regQ;
    if (anyLoad) begin
      regNext          = mergedVal;
      regNext[SLP_BIT] = 1'b0;
    end
    if (stb.sciSet)
      regNext[SCI_BIT] = 1'b1;
    else if (stb.sciClr)
      regNext[SCI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ          <= '0;
      regQ[SCI_BIT] <= acpiOnly;
    end else begin
      regQ <= regNext;
    end
  end

  // Read lanes: offset n returns the register shifted down by n lanes
  logic [RegW-1:0] laneView [Lanes];
  for (genvar g = 0; g < Lanes; g++) begin : gLane
    assign laneView[g] = regQ >> (LaneW * g);
  end
  assign rdData = laneView[rdAddr];

  AST_SLP_NOT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> !rdData[SLP_BIT]) else $error("sleep bit stored"); // R2
  AST_UPPER_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadUpper && !stb.sciSet && !stb.sciClr) |=> $stable(regQ[LaneW-1:0]))
    else $error("low byte changed"); // R4
  AST_ACPI_ONLY_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (acpiOnly && !stb.loadFull && !stb.loadLow) |=> $stable(regQ[SCI_BIT]))
    else $error("SCI bit moved in fixed mode"); // R11
endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_sleep_pkg::*;
#(
  parameter int TYP_W    = 3,
  parameter int OFF_CODE = 0,
  parameter int RAM_CODE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acpiOnly,
  input  logic [TYP_W-1:0] diskCode,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busHalf,
  input  logic             sciSetCmd,
  input  logic             sciClrCmd,
  input  logic             wrSleep,
  input  logic [TYP_W-1:0] wrType,
  output ctrlStb_t         stb,
  output logic             reqPowerOff,
  output logic             reqSuspend,
  output logic             reqDisk
);
  localparam logic [TYP_W-1:0] OffCode = TYP_W'(OFF_CODE);
  localparam logic [TYP_W-1:0] RamCode = TYP_W'(RAM_CODE);

  logic atLow;
  logic sleepReq;
  logic hitOff;
  logic hitRam;
  logic hitDisk;

  assign atLow = (busAddr == '0);

  always_comb begin
    stb.loadFull  = busWr &  busHalf &  atLow;
    stb.loadLow   = busWr & ~busHalf &  atLow;
    stb.loadUpper = busWr & ~busHalf & ~atLow;
    stb.sciSet    = sciSetCmd & ~acpiOnly;
    stb.sciClr    = sciClrCmd & ~sciSetCmd & ~acpiOnly;
  end

  assign sleepReq = (stb.loadFull | stb.loadLow | stb.loadUpper) & wrSleep;
  assign hitOff   = sleepReq && (wrType == OffCode);
  assign hitRam   = sleepReq && (wrType == RamCode);
  assign hitDisk  = sleepReq && (wrType != OffCode) && (wrType != RamCode)
                    && (wrType == diskCode);

  // Disk request is followed by power-off: its own pulse feeds the off pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPowerOff <= 1'b0;
      reqSuspend  <= 1'b0;
      reqDisk     <= 1'b0;
    end else begin
      reqPowerOff <= hitOff | reqDisk;
      reqSuspend  <= hitRam;
      reqDisk     <= hitDisk;
    end
  end

  AST_DISK_THEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    reqDisk |=> reqPowerOff) else $error("disk not followed by off"); // R8
  AST_DISK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqDisk |-> $past(busWr)) else $error("disk without write"); // R8
  AST_RAM_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqSuspend |-> $past(busWr)) else $error("suspend without write"); // R7
  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    reqPowerOff |-> ($past(busWr) || $past(reqDisk))) else $error("stray off"); // R6
endmodule

// File: rtl/pm_sleep_top.sv
module pm_sleep_top
  import pm_sleep_pkg::*;
#(
  parameter int SCI_BIT  = 0,
  parameter int SLP_BIT  = 13,
  parameter int TYP_LSB  = 10,
  parameter int TYP_W    = 3,
  parameter int OFF_CODE = 0,
  parameter int RAM_CODE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acpiOnly,
  input  logic [TYP_W-1:0] diskCode,
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busHalf,
  input  logic [RegW-1:0]  busWdata,
  output logic [RegW-1:0]  busRdata,
  input  logic             sciSetCmd,
  input  logic             sciClrCmd,
  output logic             reqPowerOff,
  output logic             reqSuspend,
  output logic             reqDisk
);
  ctrlStb_t         stb;
  logic             wrSleep;
  logic [TYP_W-1:0] wrType;

  pm_sleep_ctl #(
    .TYP_W(TYP_W), .OFF_CODE(OFF_CODE), .RAM_CODE(RAM_CODE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .acpiOnly(acpiOnly), .diskCode(diskCode),
    .busAddr(busAddr), .busWr(busWr), .busHalf(busHalf),
    .sciSetCmd(sciSetCmd), .sciClrCmd(sciClrCmd),
    .wrSleep(wrSleep), .wrType(wrType), .stb(stb),
    .reqPowerOff(reqPowerOff), .reqSuspend(reqSuspend), .reqDisk(reqDisk)
  );

  pm_sleep_dp #(
    .SCI_BIT(SCI_BIT), .SLP_BIT(SLP_BIT), .TYP_LSB(TYP_LSB), .TYP_W(TYP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .acpiOnly(acpiOnly), .stb(stb),
    .wrData(busWdata), .rdAddr(busAddr), .rdData(busRdata),
    .wrSleep(wrSleep), .wrType(wrType)
  );
endmodule

// File: tb/pm_sleep_top_tb.sv
`timescale 1ns/100ps
module pm_sleep_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acpiOnly = 1'b0;
  logic [2:0]  diskCode = 3'd4;
  logic        busAddr = 1'b0;
  logic        busWr = 1'b0;
  logic        busHalf = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        sciSetCmd = 1'b0;
  logic        sciClrCmd = 1'b0;
  logic        reqPowerOff, reqSuspend, reqDisk;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pm_sleep_top u_dut (
    .clk(clk), .rstN(rstN), .acpiOnly(acpiOnly), .diskCode(diskCode),
    .busAddr(busAddr), .busWr(busWr), .busHalf(busHalf), .busWdata(busWdata),
    .busRdata(busRdata), .sciSetCmd(sciSetCmd), .sciClrCmd(sciClrCmd),
    .reqPowerOff(reqPowerOff), .reqSuspend(reqSuspend), .reqDisk(reqDisk)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic only, input logic [2:0] code);
    @(negedge clk);
    rstN = 1'b0; acpiOnly = only; diskCode = code;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive at negedge, return 1 ns after the capturing edge
  task automatic doWrite(input logic a, input logic half, input logic [15:0] d,
                         input logic setC, input logic clrC);
    @(negedge clk);
    busAddr = a; busHalf = half; busWdata = d; busWr = 1'b1;
    sciSetCmd = setC; sciClrCmd = clrC;
    @(posedge clk); #1;
    busWr = 1'b0; sciSetCmd = 1'b0; sciClrCmd = 1'b0;
  endtask

  task automatic doCmd(input logic setC, input logic clrC);
    @(negedge clk);
    sciSetCmd = setC; sciClrCmd = clrC;
    @(posedge clk); #1;
    sciSetCmd = 1'b0; sciClrCmd = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic readChk(input logic a, input logic [15:0] exp, input string tag);
    busAddr = a; #0.5;
    chk(tag, busRdata, exp);
    busAddr = 1'b0;
  endtask

  task automatic pulseChk(input logic o, input logic s, input logic dk, input string tag);
    chk(tag, {13'd0, reqPowerOff, reqSuspend, reqDisk}, {13'd0, o, s, dk});
  endtask

  task automatic t_reset_normal();
    doReset(1'b0, 3'd4);
    step();
    readChk(1'b0, 16'h0000, "R1 reset normal");
    pulseChk(0, 0, 0, "R1 no pulses after reset");
  endtask

  task automatic t_writes();
    doWrite(1'b0, 1'b1, 16'h1234, 0, 0);
    pulseChk(0, 0, 0, "R9 no sleep-enable no pulse");
    readChk(1'b0, 16'h1234, "R3 halfword store");
    doWrite(1'b0, 1'b0, 16'hFFAB, 0, 0);
    readChk(1'b0, 16'h00AB, "R3 byte0 clears upper");
    readChk(1'b1, 16'h0000, "R5 read offset1 zero");
    doWrite(1'b0, 1'b1, 16'h00CD, 0, 0);
    doWrite(1'b1, 1'b0, 16'h005A, 0, 0);
    readChk(1'b0, 16'h5ACD, "R4 upper byte keeps low");
    readChk(1'b1, 16'h005A, "R5 read offset1 shifted");
    doWrite(1'b1, 1'b1, 16'hFFFF, 0, 0);
    readChk(1'b0, 16'h5ACD, "R3 halfword at offset1 ignored");
  endtask

  task automatic t_sleep_off();
    doWrite(1'b0, 1'b1, 16'h20F0, 0, 0);
    pulseChk(1, 0, 0, "R6 off pulse");
    readChk(1'b0, 16'h00F0, "R2 sleep bit not stored");
    step();
    pulseChk(0, 0, 0, "R6 off single cycle");
  endtask

  task automatic t_suspend();
    doWrite(1'b0, 1'b1, 16'h2400, 0, 0);
    pulseChk(0, 1, 0, "R7 suspend pulse");
    step();
    pulseChk(0, 0, 0, "R7 suspend single cycle");
    doWrite(1'b0, 1'b1, 16'h0011, 0, 0);
    doWrite(1'b1, 1'b0, 16'h0024, 0, 0);
    pulseChk(0, 1, 0, "R4 upper-byte sleep write suspends");
    readChk(1'b0, 16'h0411, "R4 upper byte stored without sleep bit");
    step();
  endtask

  task automatic t_disk(input logic [15:0] val, input string tag);
    doWrite(1'b0, 1'b1, val, 0, 0);
    pulseChk(0, 0, 1, {tag, " disk pulse"});
    step();
    pulseChk(1, 0, 0, {tag, " off follows disk"});
    step();
    pulseChk(0, 0, 0, {tag, " sequence ends"});
  endtask

  task automatic t_ignored(input logic [15:0] val, input string tag);
    doWrite(1'b0, 1'b1, val, 0, 0);
    pulseChk(0, 0, 0, tag);
    step();
    pulseChk(0, 0, 0, tag);
  endtask

  task automatic t_sci();
    doWrite(1'b0, 1'b1, 16'h0000, 0, 0);
    doCmd(1, 0);
    readChk(1'b0, 16'h0001, "R10 set command");
    doCmd(1, 1);
    readChk(1'b0, 16'h0001, "R10 set wins over clear");
    doCmd(0, 1);
    readChk(1'b0, 16'h0000, "R10 clear command");
    doWrite(1'b0, 1'b1, 16'h0100, 1, 0);
    readChk(1'b0, 16'h0101, "R10 set overrides write");
    doWrite(1'b0, 1'b1, 16'h0101, 0, 1);
    readChk(1'b0, 16'h0100, "R10 clear overrides write");
  endtask

  task automatic t_acpi_only();
    doReset(1'b1, 3'd1);
    step();
    readChk(1'b0, 16'h0001, "R1 reset fixed mode");
    doCmd(0, 1);
    readChk(1'b0, 16'h0001, "R11 clear ignored");
    doWrite(1'b0, 1'b1, 16'h0000, 0, 0);
    readChk(1'b0, 16'h0000, "R11 software write still clears");
    doCmd(1, 0);
    readChk(1'b0, 16'h0000, "R11 set ignored");
    doWrite(1'b0, 1'b1, 16'h2400, 0, 0);
    pulseChk(0, 1, 0, "R9 type1 stays suspend with diskCode 1");
    step();
    t_ignored(16'h3C00, "R9 type7 silent with diskCode 1");
  endtask

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_normal();
    t_writes();
    t_sleep_off();
    t_suspend();
    t_disk(16'h3000, "R8 code4");
    t_ignored(16'h3400, "R9 type5 no request");
    t_ignored(16'h2800, "R9 type2 no request");
    t_sci();
    t_acpi_only();
    doReset(1'b0, 3'd7);
    step();
    t_disk(16'h3C00, "R8 code7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule